// File: doc/BRIEF.md
# Programmable Start-of-Frame Delimiter Detector and Receive Byte Assembler

This block sits behind a receive bit slicer. It watches a serial bit stream for a start-of-frame delimiter that software sets up as zero to three bytes with any bit pattern. Once the delimiter has gone by, every later bit is packed into bytes, and each byte is written into a small receive FIFO. The FIFO is drained through a valid/ready read port. A DMA request is raised whenever the FIFO holds data. Preamble and delimiter bits never reach the FIFO. Anything that follows the delimiter, a PHY header for example, is kept.

Software arms a search with `arm`. The comparator then slides over the incoming bits until the last 8×L received bits equal the programmed pattern, where L is the delimiter length. An external detector can take the comparator's place when `ext_sfd_en` is set. A match produces:
- a one-cycle frame-detect strobe, which the transmit path can also raise, and
- a sticky delimiter-found flag with a maskable interrupt.

The serial side has no back-pressure. A bit is taken on every cycle that `rx_bit_valid` is high. If the FIFO is full when a byte completes, that byte is lost and a sticky overflow flag is set. On the read side, a byte is removed on each cycle where `rd_valid` and `rd_ready` are both high. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.

Top module: `sfd_rx_assembler`

## Requirements
- R1: `sfd_len` (2 bits) selects a delimiter of 0, 1, 2 or 3 bytes. With length 0, a pulse on `arm` goes straight to data mode, and the first valid bit after the arm cycle becomes data bit 0.
- R2: The pattern is `sfd_pattern[8k+7:8k]` for byte k. Byte 0 is the first on the air, and within each byte bit 0 comes first. The comparator slides one bit at a time. It can match only once at least 8×L valid bits have arrived since `arm`, and it matches on the cycle of the last delimiter bit.
- R3: Delimiter matching ignores `bit_order`.
- R4: While `ext_sfd_en` is 1, the internal comparator is ignored. `ext_sfd_found` sampled high during the search ends the search, and that cycle's bit is not stored.
- R5: `frame_det` is high for exactly the one cycle after a delimiter match, and also for the one cycle after a `tx_sfd_sent` pulse.
- R6: `sfd_found` is set by a match and held until the next `arm`. `irq` equals `sfd_found & irq_unmask`.
- R7: Delimiter bits and bits before it are not stored. Later bits are packed into bytes: bit 0 is filled first when `bit_order`=0, and bit 7 is filled first when `bit_order`=1.
- R8: The FIFO holds at most 15 bytes and reads them out in arrival order. `byte_count` (4 bits) gives the number of stored bytes, and `rd_valid` is high when `byte_count` is not zero.
- R9: `dma_req` is high whenever the FIFO is not empty, in any receive state, including idle after `rx_stop`.
- R10: A byte that completes while the FIFO holds 15 bytes is dropped, even if a read happens in the same cycle. The drop sets `overflow`, which stays set until the next `arm`.
- R11: `rx_stop` returns the block to idle and throws away a partly packed byte. Bits are ignored while idle and in the `arm` cycle, and the FIFO contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a delimiter search; clears status flags |
| rx_stop | input | 1 | End of frame; return to idle |
| rx_bit | input | 1 | Serial receive bit |
| rx_bit_valid | input | 1 | `rx_bit` is valid this cycle |
| sfd_len | input | 2 | Delimiter length in bytes (0..3) |
| sfd_pattern | input | 24 | Delimiter pattern, byte 0 sent first |
| bit_order | input | 1 | Data packing order: 0 = bit 0 first, 1 = bit 7 first |
| ext_sfd_en | input | 1 | Use the external delimiter-found input |
| ext_sfd_found | input | 1 | External delimiter-found indication |
| tx_sfd_sent | input | 1 | Transmit path sent its delimiter |
| irq_unmask | input | 1 | Delimiter interrupt enable |
| rd_ready | input | 1 | Reader accepts `rd_data` |
| rd_valid | output | 1 | FIFO has a byte |
| rd_data | output | 8 | Oldest FIFO byte |
| byte_count | output | 4 | Bytes in FIFO |
| dma_req | output | 1 | DMA request, FIFO not empty |
| frame_det | output | 1 | Frame boundary strobe |
| sfd_found | output | 1 | Sticky delimiter-found status |
| irq | output | 1 | Masked delimiter interrupt |
| overflow | output | 1 | Sticky FIFO overflow |

## Verification
The bench feeds repeated partial copies of a pattern ahead of the real delimiter. This exposes a comparator that resets on a mismatch instead of sliding, because such a design misses the real delimiter. The bench also checks that no strobe fires before 8×L bits have arrived: a design that compares stale shift-register contents would report a match too early.

Three further checks cover packing and storage:
- Packing is checked in both bit orders, with a delimiter sent in each, so that a design that let `bit_order` reach the comparator would fail to match.
- The FIFO is filled past 15 bytes, catching designs that wrap and overwrite data, or that report a count of 16 or 0.
- The bench reads the FIFO after `rx_stop` to confirm that `dma_req` does not depend on the receive state.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_SEARCH = 2'd1,
    RX_DATA   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sfd_matcher.sv
module sfd_matcher #(
  parameter int unsigned MAX_BYTES = 3,
  parameter int unsigned LEN_W     = 2,
  localparam int unsigned WIN_W    = MAX_BYTES * sfd_pkg::BYTE_W,
  localparam int unsigned SEEN_W   = $clog2(WIN_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              searching,
  input  logic              bit_v,
  input  logic              bit_in,
  input  logic [LEN_W-1:0]  len,
  input  logic [WIN_W-1:0]  pattern,
  input  logic              ext_en,
  input  logic              ext_found,
  output logic              hit
);
  logic [WIN_W-1:0]  win_q, win_nxt, mask, expect_v;
  logic [SEEN_W-1:0] seen_q, seen_nxt;
  logic              int_hit;
  int unsigned       sh;

  always_comb begin
    win_nxt  = {bit_in, win_q[WIN_W-1:1]};
    seen_nxt = (seen_q == SEEN_W'(WIN_W)) ? seen_q : seen_q + 1'b1;
    sh       = WIN_W - sfd_pkg::BYTE_W * int'(len);
    mask     = (sh >= WIN_W) ? '0 : ~({WIN_W{1'b1}} >> (WIN_W - sh));
    expect_v = (sh >= WIN_W) ? '0 : (pattern << sh);
    int_hit  = bit_v && (len != '0) &&
               (32'(seen_nxt) >= sfd_pkg::BYTE_W * int'(len)) &&
               ((win_nxt & mask) == (expect_v & mask));
    if (!searching)  hit = 1'b0;
    else if (ext_en) hit = ext_found;
    else             hit = int_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      win_q  <= '0;
      seen_q <= '0;
    end else if (searching && bit_v) begin
      win_q  <= win_nxt;
      seen_q <= seen_nxt;
    end
  end
endmodule

// File: rtl/sfd_byte_packer.sv
module sfd_byte_packer #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_v,
  input  logic              bit_in,
  input  logic              msb_first,
  output logic              push,
  output logic [DATA_W-1:0] byte_out
);
  logic [DATA_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q, pos;

  always_comb begin
    pos      = msb_first ? IDX_W'(DATA_W - 1) - idx_q : idx_q;
    byte_out = acc_q;
    byte_out[pos] = bit_in;
    push     = bit_v && (idx_q == IDX_W'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (bit_v) begin
      acc_q <= push ? '0 : byte_out;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_rx_fifo.sv
module sfd_rx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 15,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok    = push && !full;
  assign drop     = push && full;
  assign rd_valid = (cnt_q != '0);
  assign rd_ok    = rd_valid && rd_ready;
  assign rdata    = mem[rptr_q];
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) rptr_q <= bump(rptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sfd_rx_assembler.sv
module sfd_rx_assembler #(
  parameter int unsigned MAX_BYTES  = 3,
  parameter int unsigned LEN_W      = 2,
  parameter int unsigned FIFO_DEPTH = 15,
  localparam int unsigned PAT_W     = MAX_BYTES * sfd_pkg::BYTE_W,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              rx_stop,
  input  logic              rx_bit,
  input  logic              rx_bit_valid,
  input  logic [LEN_W-1:0]  sfd_len,
  input  logic [PAT_W-1:0]  sfd_pattern,
  input  logic              bit_order,
  input  logic              ext_sfd_en,
  input  logic              ext_sfd_found,
  input  logic              tx_sfd_sent,
  input  logic              irq_unmask,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [CNT_W-1:0]  byte_count,
  output logic              dma_req,
  output logic              frame_det,
  output logic              sfd_found,
  output logic              irq,
  output logic              overflow
);
  import sfd_pkg::*;

  rx_state_e state_q;
  logic      searching, in_data, bit_take, hit, arm_hit0, match;
  logic      push, drop, fd_q, found_q, ovf_q;
  logic [7:0] pk_byte;

  assign bit_take  = rx_bit_valid && !arm && !rx_stop;
  assign searching = (state_q == RX_SEARCH) && !arm && !rx_stop;
  assign in_data   = (state_q == RX_DATA) && bit_take;
  assign arm_hit0  = arm && (sfd_len == '0);
  assign match     = hit || arm_hit0;

  sfd_matcher #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (arm),
    .searching (searching),
    .bit_v     (bit_take),
    .bit_in    (rx_bit),
    .len       (sfd_len),
    .pattern   (sfd_pattern),
    .ext_en    (ext_sfd_en),
    .ext_found (ext_sfd_found),
    .hit       (hit)
  );

  sfd_byte_packer #(.DATA_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state_q != RX_DATA),
    .bit_v     (in_data),
    .bit_in    (rx_bit),
    .msb_first (bit_order),
    .push      (push),
    .byte_out  (pk_byte)
  );

  sfd_rx_fifo #(.DATA_W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .wdata    (pk_byte),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rdata    (rd_data),
    .count    (byte_count),
    .drop     (drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      fd_q    <= 1'b0;
      found_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      fd_q <= match || tx_sfd_sent;
      if (rx_stop)       state_q <= RX_IDLE;
      else if (arm)      state_q <= arm_hit0 ? RX_DATA : RX_SEARCH;
      else if (hit)      state_q <= RX_DATA;
      if (arm)           found_q <= arm_hit0;
      else if (hit)      found_q <= 1'b1;
      if (arm)           ovf_q   <= 1'b0;
      else if (drop)     ovf_q   <= 1'b1;
    end
  end

  assign frame_det = fd_q;
  assign sfd_found = found_q;
  assign irq       = found_q && irq_unmask;
  assign overflow  = ovf_q;
  assign dma_req   = rd_valid;
endmodule

// File: rtl/sfd_rx_assembler_chk.sv
module sfd_rx_assembler_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DEPTH = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             irq,
  input logic             irq_unmask,
  input logic             sfd_found,
  input logic [CNT_W-1:0] byte_count,
  input logic             dma_req,
  input logic             overflow
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) byte_count <= CNT_W'(DEPTH)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (byte_count == $past(byte_count)) || (byte_count == $past(byte_count) + 1'b1) || (byte_count == $past(byte_count) - 1'b1)); // R8
  AST_DMA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) dma_req == (byte_count != '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irq_unmask && sfd_found)); // R6
  AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sfd_found && !arm) |=> sfd_found); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overflow && !arm) |=> overflow); // R10
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(overflow) |-> $past(byte_count) == CNT_W'(DEPTH)); // R10
endmodule

bind sfd_rx_assembler sfd_rx_assembler_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .irq        (irq),
  .irq_unmask (irq_unmask),
  .sfd_found  (sfd_found),
  .byte_count (byte_count),
  .dma_req    (dma_req),
  .overflow   (overflow)
);

// File: tb/sfd_rx_assembler_tb.sv
module sfd_rx_assembler_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, rx_stop = 0, rx_bit = 0, rx_bit_valid = 0;
  logic [1:0] sfd_len = 0;
  logic [23:0] sfd_pattern = 0;
  logic bit_order = 0, ext_sfd_en = 0, ext_sfd_found = 0, tx_sfd_sent = 0;
  logic irq_unmask = 0, rd_ready = 0;
  logic rd_valid, dma_req, frame_det, sfd_found, irq, overflow;
  logic [7:0] rd_data;
  logic [3:0] byte_count;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfd_rx_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rx_stop(rx_stop), .rx_bit(rx_bit),
    .rx_bit_valid(rx_bit_valid), .sfd_len(sfd_len), .sfd_pattern(sfd_pattern),
    .bit_order(bit_order), .ext_sfd_en(ext_sfd_en), .ext_sfd_found(ext_sfd_found),
    .tx_sfd_sent(tx_sfd_sent), .irq_unmask(irq_unmask), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .byte_count(byte_count), .dma_req(dma_req),
    .frame_det(frame_det), .sfd_found(sfd_found), .irq(irq), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7 - i];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; rx_bit_valid = 1;
    @(negedge clk); rx_bit_valid = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); rx_stop = 1;
    @(negedge clk); rx_stop = 0;
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset count", byte_count, 0);
    chk("R9 reset dma", dma_req, 0);
    chk("R5 reset fdet", frame_det, 0);
    chk("R6 reset found", sfd_found, 0);
    chk("R10 reset ovf", overflow, 0);
  endtask

  // R2 R7: one-byte delimiter, bits before arm ignored (R11), LSB-first packing
  task automatic t_len1();
    sfd_len = 1; sfd_pattern = 24'h0000A5; bit_order = 0; irq_unmask = 1;
    send_byte(8'hA5);
    chk("R11 idle bits ignored", byte_count, 0);
    pulse_arm();
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    send_byte(8'hA5);
    chk("R5 fdet after match", frame_det, 1);
    chk("R6 found", sfd_found, 1);
    chk("R6 irq unmasked", irq, 1);
    chk("R7 delimiter not stored", byte_count, 0);
    @(negedge clk);
    chk("R5 fdet one cycle", frame_det, 0);
    irq_unmask = 0; #1;
    chk("R6 irq masked", irq, 0);
    send_byte(8'h3C);
    send_byte(8'hE1);
    chk("R8 count two", byte_count, 2);
    chk("R9 dma nonempty", dma_req, 1);
    pulse_stop();
    chk("R9 dma after stop", dma_req, 1);
    read_expect("R7 lsb first", 8'h3C);
    read_expect("R8 order", 8'hE1);
    chk("R8 empty", byte_count, 0);
  endtask

  // R2: sliding match with repeated partial prefix, no early match
  task automatic t_len2_slide();
    sfd_len = 2; sfd_pattern = 24'h003CA5; bit_order = 0;
    pulse_arm();
    chk("R6 arm clears found", sfd_found, 0);
    send_byte(8'hA5);
    chk("R2 no early match", sfd_found, 0);
    send_byte(8'hA5);
    send_byte(8'h3C);
    chk("R2 sliding match", frame_det, 1);
    send_byte(8'h5A);
    read_expect("R2 data after slide", 8'h5A);
    pulse_stop();
  endtask

  // R3 R7: three bytes, bit_order=1 packing, match unaffected
  task automatic t_len3_msb();
    sfd_len = 3; sfd_pattern = 24'hC3_81_F0; bit_order = 1;
    pulse_arm();
    send_byte(8'hF0); send_byte(8'h81);
    chk("R2 partial no match", sfd_found, 0);
    send_byte(8'hC3);
    chk("R3 match ignores bit_order", sfd_found, 1);
    send_byte(8'h12);
    read_expect("R7 msb first", rev8(8'h12));
    pulse_stop();
  endtask

  // R1: length zero starts data on first bit after arm
  task automatic t_len0();
    sfd_len = 0; bit_order = 0;
    pulse_arm();
    chk("R1 len0 fdet", frame_det, 1);
    chk("R1 len0 found", sfd_found, 1);
    send_byte(8'h96);
    read_expect("R1 len0 first byte", 8'h96);
    pulse_stop();
  endtask

  // R4: external detect replaces comparator
  task automatic t_ext();
    sfd_len = 1; sfd_pattern = 24'h0000FF; ext_sfd_en = 1;
    pulse_arm();
    send_byte(8'hFF);
    chk("R4 internal ignored", sfd_found, 0);
    @(negedge clk); rx_bit = 1; rx_bit_valid = 1; ext_sfd_found = 1;
    @(negedge clk); rx_bit_valid = 0; ext_sfd_found = 0;
    chk("R4 ext found", frame_det, 1);
    send_byte(8'h4B);
    read_expect("R4 ext data, marker bit dropped", 8'h4B);
    ext_sfd_en = 0;
    pulse_stop();
  endtask

  // R5: transmit path strobe
  task automatic t_tx();
    @(negedge clk); tx_sfd_sent = 1;
    @(negedge clk); tx_sfd_sent = 0;
    chk("R5 tx fdet", frame_det, 1);
    @(negedge clk);
    chk("R5 tx fdet clears", frame_det, 0);
  endtask

  // R10 R11: overflow and partial discard
  task automatic t_overflow();
    sfd_len = 0; bit_order = 0;
    pulse_arm();
    for (int k = 0; k < 16; k++) send_byte(8'(k + 8'h20));
    chk("R8 count saturates at 15", byte_count, 15);
    chk("R10 overflow set", overflow, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    pulse_stop();
    for (int k = 0; k < 15; k++) read_expect("R10 kept bytes", 8'(k + 8'h20));
    chk("R11 partial discarded", byte_count, 0);
    chk("R10 overflow sticky", overflow, 1);
    pulse_arm();
    chk("R10 arm clears ovf", overflow, 0);
    send_byte(8'h77);
    read_expect("R11 fresh byte alignment", 8'h77);
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_len1();
    t_len2_slide();
    t_len3_msb();
    t_len0();
    t_ext();
    t_tx();
    t_overflow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule